// File: doc/BRIEF.md
# Page-Mode ROM Access Controller

This block runs read cycles to external ROM or flash parts that sit behind three chip selects. Select 0 is the boot device. Selects 1 and 2 are general devices. Each select has its own settings:
- which data bus the device drives,
- device width (8, 16 or 32 bits),
- page or non-page timing,
- two 4-bit wait counts.

The boot device's bus choice and width are captured from strap inputs when power-good rises. Software writes those two settings for the other selects.

A request carries a select, a byte address and a size code. The block latches the settings of that select. It then drives the select low and puts one address per beat on the address bus. It counts the wait states of each beat and gathers the bytes from the chosen bus into one little-endian word. When the last beat has been taken, it pulses a ready strobe.

A narrow device turns a wide request into several beats. In page mode, beats that follow in the same page use the short wait count. A beat that crosses into a new page pays the long count again. Every new request pays the long count on its first beat.

Top module: `rom_page_ctrl`

## Requirements
- R1: After reset, every chip select output is high and `busy` and `rd_ready` are low. Every select starts in non-page mode with both wait counts at 15. The general selects start with bus 0 and width code 0.
- R2: On the cycle `pwr_good` goes from 0 to 1, the boot select captures `strap_loc` as its bus choice and `strap_width` as its width code. Later strap changes have no effect. A configuration write to select 0 changes only its mode and wait counts, never its bus or width.
- R3: During an access, `rom_bus_sdram` equals the bus bit of the active select (1 = second data bus, 0 = general data bus). Read data is taken from that bus.
- R4: Width code 0 means 8 bits, 1 means 16 bits, and 2 or 3 means 32 bits. The beat count is the request size divided by the device width, and at least 1. The address starts at `req_addr` and goes up by the device width in bytes on each beat.
- R5: In non-page mode, every beat lasts first-wait + 1 cycles.
- R6: In page mode, the first beat lasts first-wait + 1 cycles. A later beat whose address is in the same page as the previous beat lasts in-page-wait + 1 cycles, and in-page-wait may be 0. The page is `PAGE_BYTES` bytes, 16 by default.
- R7: In page mode, a beat whose address lies in a different page from the previous beat lasts first-wait + 1 cycles.
- R8: Every request opens with the first-wait count, even when its address directly follows the previous request in the same page.
- R9: `rd_data` byte k holds the device byte at `req_addr` + k for each k below the request size. Bytes above the size are zero. Size code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes.
- R10: `rd_ready` is a one-cycle pulse. It rises T cycles after the accepting clock edge, where T is the sum of (wait + 1) over all beats.
- R11: A request is accepted only in idle and only when `req_sel` is 0, 1 or 2. At most one chip select is low at a time, and bit s of `rom_cs_n` belongs to select s.
- R12: All chip selects are high in the `rd_ready` cycle, so they stay high for at least one cycle between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Power-good; its rising edge captures the boot straps |
| strap_loc | input | 1 | Boot device bus strap |
| strap_width | input | 2 | Boot device width strap |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Select whose settings are written |
| cfg_wdata | input | 12 | [11] bus, [10:9] width, [8] page mode, [7:4] first wait, [3:0] in-page wait |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 2 | Target chip select |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 2 | Size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| gp_rdata | input | 32 | General data bus |
| sd_rdata | input | 32 | Second data bus |
| rom_cs_n | output | 3 | Active-low chip selects |
| rom_addr | output | ADDR_W | Device byte address |
| rom_bus_sdram | output | 1 | Active bus indicator |
| busy | output | 1 | High from accept through the ready cycle |
| rd_ready | output | 1 | Read word valid strobe |
| rd_data | output | 32 | Assembled read word |

## Verification
The bench computes T for each request from its own copy of the settings, beat by beat. It takes the wait count of each beat from the mode and from whether the beat stays in the previous beat's page, then adds one cycle per beat. Each expected item carries the cycle number at which `rd_ready` must appear, counted from the accepting edge. The monitor samples on the falling edge and compares that number with the cycle it sees the strobe. Chip select and bus indicator are checked on every falling edge of an access, and the select lines are checked again in the ready cycle.

// File: rtl/rom_page_pkg.sv
// Package: shared settings record and width decoding for the page-mode ROM controller.
// Assumes a 32-bit read word and 4-bit wait counts.
package rom_page_pkg;
    localparam int WAIT_W = 4;
    localparam int WORD_BYTES = 4;

    typedef struct packed {
        logic              loc;      // 1: second data bus
        logic [1:0]        width;    // 0: 8b, 1: 16b, 2/3: 32b
        logic              page;     // 1: page mode
        logic [WAIT_W-1:0] first_w;  // first-access wait
        logic [WAIT_W-1:0] page_w;   // in-page wait
    } sel_cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_DONE} seq_state_t;

    // log2 of a width or size code in bytes; code 3 behaves as code 2
    function automatic logic [1:0] code_log(input logic [1:0] c);
        return (c == 2'd3) ? 2'd2 : c;
    endfunction
endpackage

// File: rtl/rom_cfg_bank.sv
// Module: per-select settings. Select 0 takes bus and width from straps
// captured on the rising edge of power-good; the other selects take all
// fields from configuration writes. Assumes pwr_good is synchronous to clk.
module rom_cfg_bank
    import rom_page_pkg::*;
#(
    parameter int NSEL = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_good,
    input  logic                   strap_loc,
    input  logic [1:0]             strap_width,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [11:0]            cfg_wdata,
    output sel_cfg_t [NSEL-1:0]    cfg_o
);
    logic pg_q;

    // Remember last power-good level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= 1'b0;
        else        pg_q <= pwr_good;
    end

    for (genvar s = 0; s < NSEL; s++) begin : g_sel
        sel_cfg_t r;
        wire hit = cfg_we && (cfg_sel == s[1:0]);

        if (s == 0) begin : g_boot
            // Boot select: straps on power-good rise, timing by write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r <= '{loc: 1'b0, width: 2'd0, page: 1'b0,
                           first_w: '1, page_w: '1};
                end else begin
                    if (pwr_good && !pg_q) begin
                        r.loc   <= strap_loc;
                        r.width <= strap_width;
                    end
                    if (hit) begin
                        r.page    <= cfg_wdata[8];
                        r.first_w <= cfg_wdata[7:4];
                        r.page_w  <= cfg_wdata[3:0];
                    end
                end
            end

            assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (pg_q || !pwr_good) |=> ($stable(r.loc) && $stable(r.width)));
        end else begin : g_gen
            // General select: every field by write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r <= '{loc: 1'b0, width: 2'd0, page: 1'b0,
                           first_w: '1, page_w: '1};
                end else if (hit) begin
                    r <= '{loc: cfg_wdata[11], width: cfg_wdata[10:9],
                           page: cfg_wdata[8], first_w: cfg_wdata[7:4],
                           page_w: cfg_wdata[3:0]};
                end
            end
        end

        assign cfg_o[s] = r;
    end
endmodule

// File: rtl/rom_beat_seq.sv
// Module: access sequencer. Accepts a request in idle, latches the select's
// settings, steps through beats with per-beat wait counts (page-aware) and
// flags each beat's capture cycle. Assumes PAGE_BYTES is a power of two.
module rom_beat_seq
    import rom_page_pkg::*;
#(
    parameter int NSEL       = 3,
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_sel,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  sel_cfg_t [NSEL-1:0] cfg_i,
    output logic [NSEL-1:0]     rom_cs_n,
    output logic [ADDR_W-1:0]   rom_addr,
    output logic                rom_bus_sdram,
    output logic                busy,
    output logic                rd_ready,
    output logic                start,
    output logic                cap,
    output logic [1:0]          beat_idx,
    output logic [1:0]          wlog,
    output logic [1:0]          blog
);
    localparam int PG_BITS = $clog2(PAGE_BYTES);

    seq_state_t          state;
    sel_cfg_t            cfg_q;
    logic [1:0]          sel_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [WAIT_W-1:0]   cnt;
    logic [1:0]          left;
    logic [ADDR_W-1:0]   next_addr;
    logic                same_page;
    sel_cfg_t            cfg_req;
    logic [1:0]          req_wl, req_bl;

    // Decode the incoming request against its select's settings
    always_comb begin
        cfg_req = cfg_i[0];
        for (int s = 0; s < NSEL; s++)
            if (req_sel == s[1:0]) cfg_req = cfg_i[s];
        req_wl = code_log(cfg_req.width);
        req_bl = code_log(req_size);
        start  = (state == ST_IDLE) && req_valid && (int'(req_sel) < NSEL);
    end

    // Next beat address and page comparison
    always_comb begin
        next_addr = addr_q + (ADDR_W'(1) << wlog);
        same_page = next_addr[ADDR_W-1:PG_BITS] == addr_q[ADDR_W-1:PG_BITS];
    end

    // Beat sequencing and wait counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            sel_q    <= '0;
            addr_q   <= '0;
            cnt      <= '0;
            left     <= '0;
            beat_idx <= '0;
            wlog     <= '0;
            blog     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_ACC;
                    cfg_q    <= cfg_req;
                    sel_q    <= req_sel;
                    addr_q   <= req_addr;
                    cnt      <= cfg_req.first_w;
                    left     <= (req_bl > req_wl) ? 2'((3'd1 << (req_bl - req_wl)) - 3'd1) : 2'd0;
                    beat_idx <= '0;
                    wlog     <= req_wl;
                    blog     <= req_bl;
                end
                ST_ACC: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (left == '0) begin
                        state <= ST_DONE;
                    end else begin
                        addr_q   <= next_addr;
                        cnt      <= (cfg_q.page && same_page) ? cfg_q.page_w : cfg_q.first_w;
                        left     <= left - 1'b1;
                        beat_idx <= beat_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    for (genvar s = 0; s < NSEL; s++) begin : g_cs
        assign rom_cs_n[s] = !((state == ST_ACC) && (sel_q == s[1:0]));
    end

    assign rom_addr      = addr_q;
    assign rom_bus_sdram = (state == ST_ACC) && cfg_q.loc;
    assign busy          = (state != ST_IDLE);
    assign rd_ready      = (state == ST_DONE);
    assign cap           = (state == ST_ACC) && (cnt == '0);

    assert_one_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~rom_cs_n));
    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);
    assert_cs_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (&rom_cs_n));
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !(&rom_cs_n)) |=> $stable(rom_addr));
    assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&rom_cs_n)) |-> (cnt <= cfg_q.first_w || cnt <= cfg_q.page_w));
endmodule

// File: rtl/rom_word_asm.sv
// Module: read word assembly. Clears on request start and drops each beat's
// low device-width bytes into the word at byte offset beat*width,
// keeping only bytes below the request size (little-endian order).
module rom_word_asm
    import rom_page_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        cap,
    input  logic [1:0]  beat_idx,
    input  logic [1:0]  wlog,
    input  logic [1:0]  blog,
    input  logic [31:0] lane,
    output logic [31:0] word
);
    int off, wb, nb;

    // Byte offset, device width and request size in bytes
    always_comb begin
        wb  = 1 << wlog;
        nb  = 1 << blog;
        off = int'(beat_idx) * wb;
    end

    // Accumulate captured bytes into the word
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            word <= '0;
        end else if (cap) begin
            for (int k = 0; k < WORD_BYTES; k++)
                if (k >= off && k < off + wb && k < nb)
                    word[8*k +: 8] <= lane[8*((k - off) & 3) +: 8];
        end
    end
endmodule

// File: rtl/rom_page_ctrl.sv
// Module: top of the page-mode ROM access controller. Joins the settings
// bank, the beat sequencer and the word assembler, and picks the data bus
// of the active select. Assumes one outstanding request at a time.
module rom_page_ctrl
    import rom_page_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              strap_loc,
    input  logic [1:0]        strap_width,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [11:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [1:0]        req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       gp_rdata,
    input  logic [31:0]       sd_rdata,
    output logic [2:0]        rom_cs_n,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_bus_sdram,
    output logic              busy,
    output logic              rd_ready,
    output logic [31:0]       rd_data
);
    localparam int NSEL = 3;

    sel_cfg_t [NSEL-1:0] cfg;
    logic        start, cap;
    logic [1:0]  beat_idx, wlog, blog;
    logic [31:0] lane;

    rom_cfg_bank #(.NSEL(NSEL)) u_cfg (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .strap_loc(strap_loc), .strap_width(strap_width),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_o(cfg)
    );

    rom_beat_seq #(.NSEL(NSEL), .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_addr(req_addr), .req_size(req_size), .cfg_i(cfg),
        .rom_cs_n(rom_cs_n), .rom_addr(rom_addr), .rom_bus_sdram(rom_bus_sdram),
        .busy(busy), .rd_ready(rd_ready), .start(start), .cap(cap),
        .beat_idx(beat_idx), .wlog(wlog), .blog(blog)
    );

    // Route the active select's data bus to the assembler
    assign lane = rom_bus_sdram ? sd_rdata : gp_rdata;

    rom_word_asm u_asm (
        .clk(clk), .rst_n(rst_n), .start(start), .cap(cap),
        .beat_idx(beat_idx), .wlog(wlog), .blog(blog),
        .lane(lane), .word(rd_data)
    );

    assert_bus_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (&rom_cs_n) |-> !rom_bus_sdram);
endmodule

// File: tb/rom_page_ctrl_test.sv
// Scoreboard bench: the driver pushes expected word and due cycle, the
// monitor pops and compares on each ready strobe.
module rom_page_ctrl_test;
    localparam int CLK_NS = 10;
    localparam int AW = 24;

    logic clk = 0, rst_n = 0, pwr_good = 0, strap_loc = 0;
    logic [1:0] strap_width = 0;
    logic cfg_we = 0;
    logic [1:0] cfg_sel = 0;
    logic [11:0] cfg_wdata = 0;
    logic req_valid = 0;
    logic [1:0] req_sel = 0, req_size = 0;
    logic [AW-1:0] req_addr = 0;
    logic [31:0] gp_rdata, sd_rdata, rd_data;
    logic [2:0] rom_cs_n;
    logic [AW-1:0] rom_addr;
    logic rom_bus_sdram, busy, rd_ready;

    int vectors = 0, errors = 0, cyc = 0;
    bit finished = 0;

    logic [31:0] q_data[$];
    int          q_due[$];
    string       q_tag[$];
    int          act_sel = -1;
    bit          act_loc = 0;

    bit       m_loc[3];
    bit [1:0] m_w[3];
    bit       m_pg[3];
    int       m_fw[3], m_pw[3];

    rom_page_ctrl uut (.*);

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] gb(input logic [AW-1:0] a);
        return a[7:0] ^ 8'hA5 ^ a[15:8];
    endfunction
    function automatic logic [7:0] sb(input logic [AW-1:0] a);
        return ~a[7:0] + 8'h3C;
    endfunction

    assign gp_rdata = {gb(rom_addr+3), gb(rom_addr+2), gb(rom_addr+1), gb(rom_addr)};
    assign sd_rdata = {sb(rom_addr+3), sb(rom_addr+2), sb(rom_addr+1), sb(rom_addr)};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input int s, input bit loc, input bit [1:0] w, input bit pg,
                          input int fw, input int pw);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'(s);
        cfg_wdata = {loc, w, pg, 4'(fw), 4'(pw)};
        @(negedge clk);
        cfg_we = 0;
        if (s != 0) begin m_loc[s] = loc; m_w[s] = w; end
        m_pg[s] = pg; m_fw[s] = fw; m_pw[s] = pw;
    endtask

    // Driver: compute expectation from the model, push, apply request
    task automatic do_req(input int s, input logic [AW-1:0] addr, input int sz,
                          input string tag, input bit poke_busy = 0);
        int wl, bl, nbeats, t, w;
        logic [AW-1:0] a, prev;
        logic [31:0] d;
        wl = (m_w[s] == 3) ? 2 : m_w[s];
        bl = (sz == 3) ? 2 : sz;
        nbeats = (bl > wl) ? (1 << (bl - wl)) : 1;
        t = 0; a = addr; prev = addr;
        for (int i = 0; i < nbeats; i++) begin
            if (i == 0) w = m_fw[s];
            else w = (m_pg[s] && a[AW-1:4] == prev[AW-1:4]) ? m_pw[s] : m_fw[s];
            t += w + 1;
            prev = a;
            a += AW'(1 << wl);
        end
        d = 0;
        for (int k = 0; k < (1 << bl); k++)
            d[8*k +: 8] = m_loc[s] ? sb(addr + AW'(k)) : gb(addr + AW'(k));
        @(negedge clk);
        q_data.push_back(d); q_due.push_back(cyc + 1 + t); q_tag.push_back(tag);
        act_sel = s; act_loc = m_loc[s];
        req_valid = 1; req_sel = 2'(s); req_addr = addr; req_size = 2'(sz);
        @(negedge clk);
        req_valid = 0;
        if (poke_busy) begin
            // R11: a request while busy must not be taken
            req_valid = 1; req_sel = 2'((s + 1) % 3); req_addr = addr + 4; req_size = 0;
            @(negedge clk);
            req_valid = 0;
        end
        while (q_data.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare ready results and per-cycle select/bus lines
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_ready) begin
                if (q_data.size() == 0) begin
                    check("R11 unexpected ready", 32'd1, 32'd0);
                end else begin
                    check(q_tag[0], rd_data, q_data[0]);
                    check("R10 ready cycle", 32'(cyc), 32'(q_due[0]));
                    check("R12 cs high at ready", 32'(rom_cs_n), 32'h7);
                    void'(q_data.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
                end
            end else if (rom_cs_n != 3'b111) begin
                check("R11 cs line", 32'(rom_cs_n), 32'(3'b111 ^ (3'b1 << act_sel)));
                check("R3 bus select", 32'(rom_bus_sdram), 32'(act_loc));
            end
        end
    end

    initial begin
        for (int s = 0; s < 3; s++) begin
            m_loc[s] = 0; m_w[s] = 0; m_pg[s] = 0; m_fw[s] = 15; m_pw[s] = 15;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 cs_n", 32'(rom_cs_n), 32'h7);
        check("R1 busy", 32'(busy), 0);
        check("R1 rd_ready", 32'(rd_ready), 0);

        // R2: straps captured at power-good rise, later changes ignored
        strap_loc = 1; strap_width = 2;
        @(negedge clk); pwr_good = 1;
        @(negedge clk); strap_loc = 0; strap_width = 0;
        m_loc[0] = 1; m_w[0] = 2;
        // R1: default waits 15, non-page, 32-bit from second bus
        do_req(0, 24'h000100, 2, "R1 R2 boot default read");
        // R2: write to select 0 must not change bus or width
        wr_cfg(0, 0, 0, 1, 3, 1);
        do_req(0, 24'h000200, 2, "R2 boot after write");
        // R9: 1-byte read from 32-bit device, upper bytes zero
        do_req(0, 24'h000203, 0, "R9 single byte");

        // R6: 8-bit page device, in-page wait 0
        wr_cfg(1, 0, 0, 1, 2, 0);
        do_req(1, 24'h000020, 2, "R6 in-page burst");
        // R7: crossing a page boundary mid-burst
        do_req(1, 24'h00002E, 2, "R7 page crossing");
        // R8: next request in same page restarts with first wait
        do_req(1, 24'h000024, 2, "R8 new request first wait");
        // R9: 2 bytes from 8-bit device
        do_req(1, 24'h00003F, 1, "R9 two byte");

        // R5: 16-bit non-page on second bus
        wr_cfg(2, 1, 1, 0, 1, 0);
        do_req(2, 24'h000040, 2, "R5 non-page 16b");
        // R7/R6: 16-bit page mode, crossing and non-crossing
        wr_cfg(2, 1, 1, 1, 4, 1);
        do_req(2, 24'h00001E, 2, "R7 16b crossing");
        do_req(2, 24'h00001A, 2, "R6 16b in page");
        // R4: width code 3 acts as 32-bit on general bus
        wr_cfg(2, 0, 3, 0, 0, 0);
        do_req(2, 24'h000081, 3, "R4 width code 3");

        // R11: request while busy is ignored
        do_req(1, 24'h000050, 2, "R11 busy poke", 1);
        repeat (20) @(negedge clk);
        check("R11 idle after poke", 32'(busy), 0);
        // R11: invalid select ignored
        req_valid = 1; req_sel = 3; req_addr = 0; req_size = 2;
        @(negedge clk); req_valid = 0;
        repeat (3) @(negedge clk);
        check("R11 invalid select busy", 32'(busy), 0);
        check("R11 invalid select cs", 32'(rom_cs_n), 32'h7);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule